// File: doc/BRIEF.md
# Indexed Integer Load Unit

This block carries out register-indexed integer loads for a 64-bit core. A decoded operation arrives with an access size, a sign-extension flag, a byte-reversal flag and an update flag. It also carries the RA and RT register numbers and the values read from RA and RB. The unit forms the effective address. It then sends one read of the requested width to a simple memory port that uses a valid/ready handshake. When the data returns, it shapes the bytes into a 64-bit result for RT.

For update forms the unit also writes the effective address back to RA. It does this on a second write port, in the same cycle as the RT result. The unit rejects encodings that have no defined load, and it handles only one operation at a time.

The returned read data has the byte at address EA+k in bits [8k+7:8k]. For plain loads the lowest-address byte is the most significant byte of the field. For byte-reversed loads it is the least significant byte.

Top module: `idx_load_unit`

## Requirements
- R1: For a non-update load whose RA field is 0, the address is the RB value alone, and the RA value is ignored.
- R2: For a non-update load whose RA field is nonzero, the address is the RA value plus the RB value, modulo 2^64.
- R3: For an update load, the address is RA value plus RB value. The address is written to the RA register number on the RA write port, in the same cycle that the RT write port first presents its result.
- R4: Each legal operation issues exactly one memory request. The request carries the address and a size code (0=1, 1=2, 2=4, 3=8 bytes). Address and size stay unchanged while the request waits for ready.
- R5: A zero-extending load of 1, 2 or 4 bytes returns the field in the low bits of RT, with the lowest-address byte most significant and all higher bits zero.
- R6: A sign-extending load of 2 or 4 bytes fills every bit above the field with the field's top bit.
- R7: A byte-reversed load of 2, 4 or 8 bytes puts the lowest-address byte in RT bits [7:0] and each following byte one position higher. Any remaining upper bits are zero.
- R8: An 8-byte plain load returns all eight bytes, the lowest address in bits [63:56].
- R9: The following operations are illegal: sign extension on 1 or 8 bytes; byte reversal on 1 byte; sign extension together with reversal; and update together with reversal. For an illegal operation, illegal_o pulses for one cycle, the cycle after acceptance. No memory request and no writeback follow.
- R10: An update load whose RA field is 0, or whose RA field equals its RT field, is illegal in the same way as in R9.
- R11: op_ready_o stays low from the accepted operation until every writeback of that operation has been acknowledged. Each write port holds its valid and data until its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Unit can accept an operation |
| op_size_i | input | 2 | Access size code (0=1, 1=2, 2=4, 3=8 bytes) |
| op_sign_i | input | 1 | Sign-extend the field |
| op_rev_i | input | 1 | Byte-reversed field |
| op_upd_i | input | 1 | Update form, write EA to RA |
| op_ra_idx_i | input | 5 | RA register number |
| op_rt_idx_i | input | 5 | RT register number |
| op_ra_val_i | input | 64 | Value of RA |
| op_rb_val_i | input | 64 | Value of RB |
| illegal_o | output | 1 | One-cycle pulse for a rejected operation |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 64 | Effective address |
| mem_size_o | output | 2 | Size code of the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read bytes, address EA+k in bits [8k+7:8k] |
| rt_we_o | output | 1 | RT write valid |
| rt_idx_o | output | 5 | RT register number |
| rt_data_o | output | 64 | RT result |
| rt_ack_i | input | 1 | RT write accepted |
| ra_we_o | output | 1 | RA write valid |
| ra_idx_o | output | 5 | RA register number |
| ra_data_o | output | 64 | Effective address for RA |
| ra_ack_i | input | 1 | RA write accepted |

## Verification
The two writebacks of an update load fall in the same cycle. The RT result and the address for RA appear together on separate ports. The bench provokes this with update forms and acknowledges the two ports in two ways: in the same cycle, or RA first with RT held back one more cycle. It judges that both valids rise together and that each result matches its expected value. It also checks that the RT port keeps its data until its own acknowledge, while op_ready_o stays low throughout.

// File: rtl/ilu_pkg.sv
package ilu_pkg;

    localparam int SZ_W = 2;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } ilu_state_e;

endpackage

// File: rtl/ilu_legal_chk.sv
module ilu_legal_chk
    import ilu_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [SZ_W-1:0]  size_i,
    input  logic             sign_i,
    input  logic             rev_i,
    input  logic             upd_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    input  logic [IDX_W-1:0] rt_idx_i,
    output logic             legal_o
);

    logic combo_ok;
    logic upd_ok;

    always_comb begin
        case (ld_size_e'(size_i))
            SZ_BYTE: combo_ok = !sign_i && !rev_i;
            SZ_HALF: combo_ok = !(sign_i && rev_i);
            SZ_WORD: combo_ok = !(sign_i && rev_i);
            SZ_DBL:  combo_ok = !sign_i;
            default: combo_ok = 1'b0;
        endcase
        upd_ok  = !upd_i || (!rev_i && (ra_idx_i != '0) && (ra_idx_i != rt_idx_i));
        legal_o = combo_ok && upd_ok;
    end

endmodule

// File: rtl/ilu_addr_gen.sv
module ilu_addr_gen #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             upd_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    input  logic [XLEN-1:0]  ra_val_i,
    input  logic [XLEN-1:0]  rb_val_i,
    output logic [XLEN-1:0]  ea_o
);

    logic            zero_base;
    logic [XLEN-1:0] base;

    always_comb begin
        zero_base = !upd_i && (ra_idx_i == '0);
        base      = zero_base ? '0 : ra_val_i;
        ea_o      = base + rb_val_i;
    end

endmodule

// File: rtl/ilu_fmt.sv
module ilu_fmt
    import ilu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw_i,
    input  logic [SZ_W-1:0] size_i,
    input  logic            sign_i,
    input  logic            rev_i,
    output logic [XLEN-1:0] res_o
);

    localparam int NB = XLEN / 8;

    int   nbytes;
    int   msb_byte;
    logic top_bit;

    always_comb begin
        nbytes   = 1 << size_i;
        msb_byte = rev_i ? nbytes - 1 : 0;
        top_bit  = raw_i[msb_byte*8 + 7];
        res_o    = '0;
        for (int j = 0; j < NB; j++) begin
            if (j < nbytes) begin
                if (rev_i) begin
                    res_o[j*8 +: 8] = raw_i[j*8 +: 8];
                end else begin
                    res_o[j*8 +: 8] = raw_i[(nbytes-1-j)*8 +: 8];
                end
            end else begin
                res_o[j*8 +: 8] = (sign_i && top_bit) ? 8'hFF : 8'h00;
            end
        end
    end

endmodule

// File: rtl/idx_load_unit.sv
module idx_load_unit
    import ilu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    output logic             op_ready_o,
    input  logic [SZ_W-1:0]  op_size_i,
    input  logic             op_sign_i,
    input  logic             op_rev_i,
    input  logic             op_upd_i,
    input  logic [IDX_W-1:0] op_ra_idx_i,
    input  logic [IDX_W-1:0] op_rt_idx_i,
    input  logic [XLEN-1:0]  op_ra_val_i,
    input  logic [XLEN-1:0]  op_rb_val_i,
    output logic             illegal_o,
    output logic             mem_req_valid_o,
    input  logic             mem_req_ready_i,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [SZ_W-1:0]  mem_size_o,
    input  logic             mem_rsp_valid_i,
    input  logic [XLEN-1:0]  mem_rsp_data_i,
    output logic             rt_we_o,
    output logic [IDX_W-1:0] rt_idx_o,
    output logic [XLEN-1:0]  rt_data_o,
    input  logic             rt_ack_i,
    output logic             ra_we_o,
    output logic [IDX_W-1:0] ra_idx_o,
    output logic [XLEN-1:0]  ra_data_o,
    input  logic             ra_ack_i
);

    typedef struct packed {
        ilu_state_e       st;
        logic [XLEN-1:0]  ea;
        logic [SZ_W-1:0]  size;
        logic             sign;
        logic             rev;
        logic             upd;
        logic [IDX_W-1:0] ra_idx;
        logic [IDX_W-1:0] rt_idx;
        logic [XLEN-1:0]  rt_data;
        logic             rt_pend;
        logic             ra_pend;
        logic             illegal;
    } ilu_regs_t;

    ilu_regs_t q, d;

    logic            op_legal;
    logic [XLEN-1:0] ea_calc;
    logic [XLEN-1:0] fmt_res;

    ilu_legal_chk #(.IDX_W(IDX_W)) u_legal (
        .size_i   (op_size_i),
        .sign_i   (op_sign_i),
        .rev_i    (op_rev_i),
        .upd_i    (op_upd_i),
        .ra_idx_i (op_ra_idx_i),
        .rt_idx_i (op_rt_idx_i),
        .legal_o  (op_legal)
    );

    ilu_addr_gen #(.XLEN(XLEN), .IDX_W(IDX_W)) u_addr (
        .upd_i    (op_upd_i),
        .ra_idx_i (op_ra_idx_i),
        .ra_val_i (op_ra_val_i),
        .rb_val_i (op_rb_val_i),
        .ea_o     (ea_calc)
    );

    ilu_fmt #(.XLEN(XLEN)) u_fmt (
        .raw_i  (mem_rsp_data_i),
        .size_i (q.size),
        .sign_i (q.sign),
        .rev_i  (q.rev),
        .res_o  (fmt_res)
    );

    always_comb begin
        d         = q;
        d.illegal = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (op_valid_i) begin
                    if (op_legal) begin
                        d.st     = ST_REQ;
                        d.ea     = ea_calc;
                        d.size   = op_size_i;
                        d.sign   = op_sign_i;
                        d.rev    = op_rev_i;
                        d.upd    = op_upd_i;
                        d.ra_idx = op_ra_idx_i;
                        d.rt_idx = op_rt_idx_i;
                    end else begin
                        d.illegal = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    d.rt_data = fmt_res;
                    d.rt_pend = 1'b1;
                    d.ra_pend = q.upd;
                    d.st      = ST_WB;
                end
            end
            ST_WB: begin
                d.rt_pend = q.rt_pend && !rt_ack_i;
                d.ra_pend = q.ra_pend && !ra_ack_i;
                if (!d.rt_pend && !d.ra_pend) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign op_ready_o      = (q.st == ST_IDLE);
    assign illegal_o       = q.illegal;
    assign mem_req_valid_o = (q.st == ST_REQ);
    assign mem_addr_o      = q.ea;
    assign mem_size_o      = q.size;
    assign rt_we_o         = (q.st == ST_WB) && q.rt_pend;
    assign rt_idx_o        = q.rt_idx;
    assign rt_data_o       = q.rt_data;
    assign ra_we_o         = (q.st == ST_WB) && q.ra_pend;
    assign ra_idx_o        = q.ra_idx;
    assign ra_data_o       = q.ea;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=>
            mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_size_o));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !mem_req_valid_o && !rt_we_o && !ra_we_o);

    // R3
    wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ra_we_o) |-> $rose(rt_we_o));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o || rt_we_o || ra_we_o) |-> !op_ready_o);

    // R11
    rt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we_o && !rt_ack_i |=> rt_we_o && $stable(rt_data_o));

endmodule

// File: tb/tb_idx_load_unit.sv
module tb_idx_load_unit;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic        op_ready_o;
    logic [1:0]  op_size_i = '0;
    logic        op_sign_i = 1'b0;
    logic        op_rev_i = 1'b0;
    logic        op_upd_i = 1'b0;
    logic [4:0]  op_ra_idx_i = '0;
    logic [4:0]  op_rt_idx_i = '0;
    logic [63:0] op_ra_val_i = '0;
    logic [63:0] op_rb_val_i = '0;
    logic        illegal_o;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [63:0] mem_addr_o;
    logic [1:0]  mem_size_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = '0;
    logic        rt_we_o;
    logic [4:0]  rt_idx_o;
    logic [63:0] rt_data_o;
    logic        rt_ack_i = 1'b0;
    logic        ra_we_o;
    logic [4:0]  ra_idx_o;
    logic [63:0] ra_data_o;
    logic        ra_ack_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_load_unit dut (
        .clk(clk), .rst_n(rst_n),
        .op_valid_i(op_valid_i), .op_ready_o(op_ready_o),
        .op_size_i(op_size_i), .op_sign_i(op_sign_i), .op_rev_i(op_rev_i),
        .op_upd_i(op_upd_i), .op_ra_idx_i(op_ra_idx_i), .op_rt_idx_i(op_rt_idx_i),
        .op_ra_val_i(op_ra_val_i), .op_rb_val_i(op_rb_val_i),
        .illegal_o(illegal_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .rt_we_o(rt_we_o), .rt_idx_o(rt_idx_o), .rt_data_o(rt_data_o), .rt_ack_i(rt_ack_i),
        .ra_we_o(ra_we_o), .ra_idx_o(ra_idx_o), .ra_data_o(ra_data_o), .ra_ack_i(ra_ack_i)
    );

    typedef struct {
        logic        ill;
        logic [63:0] addr;
        logic [1:0]  size;
        logic [63:0] rt_data;
        logic        upd;
        logic [4:0]  ra_idx;
        logic [4:0]  rt_idx;
        int          stall;
        int          mode;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [1:0] sz,
                                          input logic sg, input logic rv);
        int n = 1 << sz;
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) begin
            if (rv) v = v | ({56'b0, mbyte(a + 64'(i))} << (8*i));
            else    v = (v << 8) | {56'b0, mbyte(a + 64'(i))};
        end
        if (sg && v[8*n-1]) v = v | (~64'h0 << (8*n));
        return v;
    endfunction

    function automatic logic is_illegal(input logic [1:0] sz, input logic sg, input logic rv,
                                        input logic up, input logic [4:0] ra, input logic [4:0] rt);
        if (sg && (sz == 2'd0 || sz == 2'd3)) return 1'b1;
        if (rv && sz == 2'd0) return 1'b1;
        if (sg && rv) return 1'b1;
        if (up && rv) return 1'b1;
        if (up && (ra == 5'd0 || ra == rt)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic drive_op(input string tag, input logic [1:0] sz, input logic sg, input logic rv,
                            input logic up, input logic [4:0] ra, input logic [4:0] rt,
                            input logic [63:0] rav, input logic [63:0] rbv,
                            input int stall, input int mode);
        exp_t e;
        e.tag    = tag;
        e.ill    = is_illegal(sz, sg, rv, up, ra, rt);
        e.addr   = ((!up && ra == 5'd0) ? 64'd0 : rav) + rbv;
        e.size   = sz;
        e.rt_data = model(e.addr, sz, sg, rv);
        e.upd    = up;
        e.ra_idx = ra;
        e.rt_idx = rt;
        e.stall  = stall;
        e.mode   = mode;
        exp_q.push_back(e);
        @(negedge clk);
        op_valid_i = 1'b1; op_size_i = sz; op_sign_i = sg; op_rev_i = rv; op_upd_i = up;
        op_ra_idx_i = ra; op_rt_idx_i = rt; op_ra_val_i = rav; op_rb_val_i = rbv;
        while (!op_ready_o) @(negedge clk);
        @(negedge clk);
        op_valid_i = 1'b0;
    endtask

    // Scoreboard monitor and memory/writeback responder
    initial begin
        bit req_seen = 0;
        bit wb_seen = 0;
        int stall_left = 0;
        int rsp_left = -1;
        forever begin
            @(negedge clk);
            rt_ack_i = 1'b0;
            ra_ack_i = 1'b0;
            mem_rsp_valid_i = 1'b0;
            if (rst_n) begin
                if (illegal_o) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected illegal_o", 64'd1, 64'd0);
                    end else begin
                        chk(exp_q[0].ill, {"R9/R10 illegal pulse ", exp_q[0].tag}, 64'd1, {63'd0, exp_q[0].ill});
                        chk(!mem_req_valid_o && !rt_we_o, {"R9 quiet ", exp_q[0].tag},
                            {62'd0, mem_req_valid_o, rt_we_o}, 64'd0);
                        void'(exp_q.pop_front());
                    end
                end
                if (mem_req_valid_o && exp_q.size() > 0) begin
                    chk(!exp_q[0].ill, {"R9 request for illegal op ", exp_q[0].tag}, 64'd1, 64'd0);
                    if (!req_seen) begin
                        req_seen = 1;
                        stall_left = exp_q[0].stall;
                        chk(mem_addr_o == exp_q[0].addr, {"R1/R2/R3 address ", exp_q[0].tag},
                            mem_addr_o, exp_q[0].addr);
                        chk(mem_size_o == exp_q[0].size, {"R4 size code ", exp_q[0].tag},
                            {62'd0, mem_size_o}, {62'd0, exp_q[0].size});
                    end else begin
                        chk(mem_addr_o == exp_q[0].addr && mem_size_o == exp_q[0].size,
                            {"R4 request held ", exp_q[0].tag}, mem_addr_o, exp_q[0].addr);
                    end
                    chk(!op_ready_o, {"R11 ready low during request ", exp_q[0].tag},
                        {63'd0, op_ready_o}, 64'd0);
                    if (stall_left == 0) begin
                        mem_req_ready_i = 1'b1;
                        rsp_left = 2;
                    end else begin
                        mem_req_ready_i = 1'b0;
                        stall_left--;
                    end
                end else begin
                    mem_req_ready_i = 1'b0;
                    req_seen = 0;
                    if (rsp_left > 1) begin
                        rsp_left--;
                    end else if (rsp_left == 1 && exp_q.size() > 0) begin
                        mem_rsp_valid_i = 1'b1;
                        for (int k = 0; k < 8; k++)
                            mem_rsp_data_i[8*k +: 8] = mbyte(exp_q[0].addr + 64'(k));
                        rsp_left = -1;
                    end
                end
                if ((rt_we_o || ra_we_o) && exp_q.size() > 0) begin
                    if (!wb_seen) begin
                        wb_seen = 1;
                        chk(rt_we_o, {"R3 rt port valid ", exp_q[0].tag}, {63'd0, rt_we_o}, 64'd1);
                        chk(ra_we_o == exp_q[0].upd, {"R3 ra port valid with rt ", exp_q[0].tag},
                            {63'd0, ra_we_o}, {63'd0, exp_q[0].upd});
                        chk(rt_data_o == exp_q[0].rt_data, {"R5/R6/R7/R8 rt data ", exp_q[0].tag},
                            rt_data_o, exp_q[0].rt_data);
                        chk(rt_idx_o == exp_q[0].rt_idx, {"R3 rt index ", exp_q[0].tag},
                            {59'd0, rt_idx_o}, {59'd0, exp_q[0].rt_idx});
                        if (exp_q[0].upd) begin
                            chk(ra_data_o == exp_q[0].addr, {"R3 ra data ", exp_q[0].tag},
                                ra_data_o, exp_q[0].addr);
                            chk(ra_idx_o == exp_q[0].ra_idx, {"R3 ra index ", exp_q[0].tag},
                                {59'd0, ra_idx_o}, {59'd0, exp_q[0].ra_idx});
                        end
                        chk(!op_ready_o, {"R11 ready low in writeback ", exp_q[0].tag},
                            {63'd0, op_ready_o}, 64'd0);
                        ra_ack_i = ra_we_o;
                        if (exp_q[0].mode == 0) begin
                            rt_ack_i = 1'b1;
                            wb_seen = 0;
                            void'(exp_q.pop_front());
                        end
                    end else begin
                        chk(rt_we_o && !ra_we_o, {"R11 rt held after ra ack ", exp_q[0].tag},
                            {62'd0, rt_we_o, ra_we_o}, 64'd2);
                        chk(rt_data_o == exp_q[0].rt_data, {"R11 rt data held ", exp_q[0].tag},
                            rt_data_o, exp_q[0].rt_data);
                        chk(!op_ready_o, {"R11 ready low while rt pending ", exp_q[0].tag},
                            {63'd0, op_ready_o}, 64'd0);
                        rt_ack_i = 1'b1;
                        wb_seen = 0;
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, run hung");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready_o && !mem_req_valid_o && !rt_we_o && !ra_we_o && !illegal_o,
            "R11/R4 reset state", {59'd0, op_ready_o, mem_req_valid_o, rt_we_o, ra_we_o, illegal_o},
            64'h10);

        // R1: RA field 0, non-update, RA value ignored
        drive_op("R1 byte ra0", 2'd0, 0, 0, 0, 5'd0, 5'd4, 64'hDEAD_BEEF_0000_0000, 64'h10, 0, 0);
        // R2, R5 plain zero-extended halfword and word
        drive_op("R2 half", 2'd1, 0, 0, 0, 5'd3, 5'd5, 64'h1000, 64'h20, 2, 0);
        drive_op("R5 word", 2'd2, 0, 0, 0, 5'd3, 5'd6, 64'h2000, 64'h84, 0, 1);
        drive_op("R2 wrap", 2'd2, 0, 0, 0, 5'd7, 5'd6, 64'hFFFF_FFFF_FFFF_FFF0, 64'h40, 0, 0);
        // R6 sign extension negative and positive
        drive_op("R6 half neg", 2'd1, 1, 0, 0, 5'd2, 5'd8, 64'h0, 64'h10, 0, 0);
        drive_op("R6 half pos", 2'd1, 1, 0, 0, 5'd2, 5'd8, 64'h0, 64'h80, 0, 0);
        drive_op("R6 word neg", 2'd2, 1, 0, 0, 5'd0, 5'd9, 64'h5, 64'h30, 1, 0);
        // R8 doubleword
        drive_op("R8 dbl", 2'd3, 0, 0, 0, 5'd1, 5'd10, 64'h300, 64'h8, 0, 0);
        // R7 byte reversed
        drive_op("R7 half rev", 2'd1, 0, 1, 0, 5'd1, 5'd11, 64'h0, 64'h16, 0, 0);
        drive_op("R7 word rev", 2'd2, 0, 1, 0, 5'd0, 5'd12, 64'h9, 64'h1C, 0, 1);
        drive_op("R7 dbl rev", 2'd3, 0, 1, 0, 5'd4, 5'd13, 64'h100, 64'h4, 3, 0);
        // R3 update forms, both ack orders
        drive_op("R3 byte upd", 2'd0, 0, 0, 1, 5'd14, 5'd15, 64'h400, 64'h2, 0, 0);
        drive_op("R3 word sign upd", 2'd2, 1, 0, 1, 5'd16, 5'd17, 64'h10, 64'h0, 1, 1);
        drive_op("R3 dbl upd", 2'd3, 0, 0, 1, 5'd18, 5'd2, 64'h7F8, 64'h8, 0, 1);
        // R9 illegal combinations
        drive_op("R9 byte sign", 2'd0, 1, 0, 0, 5'd1, 5'd2, 64'h0, 64'h0, 0, 0);
        drive_op("R9 dbl sign", 2'd3, 1, 0, 0, 5'd1, 5'd2, 64'h0, 64'h0, 0, 0);
        drive_op("R9 byte rev", 2'd0, 0, 1, 0, 5'd1, 5'd2, 64'h0, 64'h0, 0, 0);
        drive_op("R9 sign rev", 2'd1, 1, 1, 0, 5'd1, 5'd2, 64'h0, 64'h0, 0, 0);
        drive_op("R9 upd rev", 2'd2, 0, 1, 1, 5'd1, 5'd2, 64'h0, 64'h0, 0, 0);
        // R10 update with RA field 0 or equal to RT
        drive_op("R10 upd ra0", 2'd1, 0, 0, 1, 5'd0, 5'd2, 64'h0, 64'h0, 0, 0);
        drive_op("R10 upd ra=rt", 2'd2, 0, 0, 1, 5'd6, 5'd6, 64'h0, 64'h0, 0, 0);
        // legal operation after rejects
        drive_op("R5 byte after reject", 2'd0, 0, 0, 0, 5'd3, 5'd1, 64'h50, 64'h1, 0, 0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(op_ready_o && !illegal_o, "R11 idle at end", {62'd0, op_ready_o, illegal_o}, 64'd2);
        finish_run();
    end

endmodule